// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several processor cores share through one simple register bus. Every access carries the ID of the bus master making it, and that ID, not the written data, is what the bank records as the owner and checks when a semaphore is released. Each semaphore stores a lock flag, the owning core ID and a process ID. This lets software separate ownership both between cores and between tasks on the same core.

A core can take a semaphore in two ways. In the first, it writes a lock request and then reads the semaphore word back to see whether it won. In the second, it reads an alias address, and that single read takes the semaphore if it is free. A release succeeds only when the requester matches the owner on both IDs. A bulk clear frees every semaphore held by one core ID, but only when the write carries a 16-bit key equal to the key register. Each core has its own enable mask and sticky status mask, so it can be told when a semaphore it is waiting on becomes free.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore reads as zero (unlocked, both IDs zero), the key register reads zero, every per-core enable and status mask is zero and every irq bit is low.
- R2: Read data is registered. `bus_rdata` shows the result of a read in the cycle after the access. A semaphore word has the lock flag at bit 31, the core ID at bits [11:8] and the process ID at bits [7:0], with all other bits zero.
- R3: A write to semaphore address i (0x00 + i) with bit 31 set takes a free semaphore. The owner core ID is recorded from `bus_mid` and the process ID from data bits [7:0].
- R4: A lock write to a semaphore that is already locked changes nothing, even when the writer is the current owner.
- R5: A read of alias address 0x20 + i takes a free semaphore in the same access. It records the reader's `bus_mid` with process ID zero and returns the new word. On a locked semaphore the read returns the current owner and leaves it unchanged.
- R6: A write with bit 31 clear frees the semaphore only if `bus_mid` equals the owner core ID and data bits [7:0] equal the owner process ID. Any other release write is ignored.
- R7: The key register at 0x41 holds data bits [15:0]. It reads back with bits [31:16] zero.
- R8: A write to 0x40 with data bits [31:16] equal to the key frees every locked semaphore whose owner equals data bits [11:8]. Semaphores owned by other cores stay locked. A wrong key frees nothing.
- R9: Core k has an enable mask at 0x48 + 4k, a write-one-to-clear register at 0x49 + 4k and a status mask readable at 0x4A + 4k, with one bit per semaphore. When semaphore i is freed while enable bit i of core k is set, status bit i of core k becomes set. Freeing a semaphore whose enable bit is clear sets nothing.
- R10: Writing ones to core k's clear register clears those status bits. `irq[k]` is high exactly when some status bit of core k is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_mid | input | CORE_W | Master (core) ID of the access |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq | output | NUM_CORE | Per-core interrupt: any enabled, set status bit |

## Verification
The assertions take for granted that at most one access reaches the bank in any cycle. Because of that, a lock request, a release, an alias read and a bulk clear never meet in the same clock, and a relock or a rejected release can be checked for a fully stable owner. The stimulus issues its accesses one at a time, each followed by an idle cycle, from two masters with IDs 0x3 and 0x1. It never drives an address outside the decoded map.

// File: rtl/sem_pkg.sv
package sem_pkg;
   localparam int          WORD_W      = 32;
   localparam int          LOCK_BIT    = 31;
   localparam int          CORE_LSB    = 8;
   localparam int          KEY_LSB     = 16;
   localparam int          KEY_W       = 16;
   localparam logic [7:0]  A_ALIAS     = 8'h20;
   localparam logic [7:0]  A_BULK      = 8'h40;
   localparam logic [7:0]  A_KEY       = 8'h41;
   localparam logic [7:0]  A_CORE      = 8'h48;

   typedef enum logic [1:0] {
      PC_EN  = 2'd0,
      PC_CLR = 2'd1,
      PC_STS = 2'd2,
      PC_RSV = 2'd3
   } pc_reg_e;
endpackage

// File: rtl/sem_cell.sv
module sem_cell #(
   parameter int CORE_W = 4,
   parameter int PROC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_wr,
   input  logic              unlock_wr,
   input  logic              rlock_rd,
   input  logic              bulk_clr,
   input  logic [CORE_W-1:0] req_core,
   input  logic [PROC_W-1:0] req_proc,
   input  logic [CORE_W-1:0] bulk_core,
   output logic              locked,
   output logic [CORE_W-1:0] own_core,
   output logic [PROC_W-1:0] own_proc,
   output logic              freed
);
   logic id_match;

   assign id_match = (req_core == own_core) && (req_proc == own_proc);
   assign freed    = locked && ((unlock_wr && id_match) ||
                                (bulk_clr && (bulk_core == own_core)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked   <= 1'b0;
         own_core <= '0;
         own_proc <= '0;
      end else if (!locked && lock_wr) begin
         locked   <= 1'b1;
         own_core <= req_core;
         own_proc <= req_proc;
      end else if (!locked && rlock_rd) begin
         locked   <= 1'b1;
         own_core <= req_core;
         own_proc <= '0;
      end else if (freed) begin
         locked   <= 1'b0;
         own_core <= '0;
         own_proc <= '0;
      end
   end

   AST_RELOCK_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      locked && lock_wr && !bulk_clr |=> locked && $stable(own_core) && $stable(own_proc)); // R4
   AST_FOREIGN_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      locked && unlock_wr && !id_match && !bulk_clr |=> locked && $stable(own_core) && $stable(own_proc)); // R6
   AST_ALIAS_TAKES_PROC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !locked && rlock_rd && !lock_wr |=> locked && own_proc == '0 && own_core == $past(req_core)); // R5
endmodule

// File: rtl/sem_irq.sv
module sem_irq #(
   parameter int NUM_SEM = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr,
   input  logic               clr_wr,
   input  logic [NUM_SEM-1:0] wmask,
   input  logic [NUM_SEM-1:0] freed,
   output logic [NUM_SEM-1:0] en_q,
   output logic [NUM_SEM-1:0] sts_q,
   output logic               irq
);
   logic [NUM_SEM-1:0] set_v;
   logic [NUM_SEM-1:0] clr_v;

   assign set_v = freed & en_q;
   assign clr_v = clr_wr ? wmask : '0;
   assign irq   = |(sts_q & en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sts_q <= '0;
      end else begin
         if (en_wr) en_q <= wmask;
         sts_q <= (sts_q & ~clr_v) | set_v;
      end
   end

   AST_STATUS_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      |set_v |=> (sts_q & $past(set_v)) == $past(set_v)); // R9
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr && ((wmask & set_v) == '0) |=> (sts_q & $past(wmask)) == '0); // R10
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM  = 32,
   parameter int NUM_CORE = 2,
   parameter int CORE_W   = 4,
   parameter int PROC_W   = 8,
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [7:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic [CORE_W-1:0]   bus_mid,
   output logic [31:0]         bus_rdata,
   output logic [NUM_CORE-1:0] irq
);
   import sem_pkg::*;

   localparam int         IDX_W   = $clog2(NUM_SEM);
   localparam logic [7:0] SEM_LIM = 8'(NUM_SEM);
   localparam logic [5:0] CORE_LIM = 6'(NUM_CORE);

   if (NUM_SEM < 2 || NUM_SEM > 32) begin : g_bad_num_sem
      $error("sem_bank: NUM_SEM must be within 2..32");
   end
   if (NUM_CORE < 1 || NUM_CORE > 45) begin : g_bad_num_core
      $error("sem_bank: NUM_CORE must be within 1..45");
   end
   if (CORE_W < 1 || CORE_W > 8 || PROC_W < 1 || PROC_W > 8) begin : g_bad_id_w
      $error("sem_bank: ID widths must be within 1..8");
   end

   logic              acc_wr, acc_rd;
   logic              in_sem, in_alias, in_core;
   logic [7:0]        alias_off, core_off;
   logic [IDX_W-1:0]  sem_idx, alias_idx;
   logic [5:0]        core_idx;
   pc_reg_e           core_reg;
   logic              bulk_hit;
   logic [KEY_W-1:0]  key_q;
   logic [31:0]       rd_next;

   logic [NUM_SEM-1:0] lock_v, freed_v;
   logic [CORE_W-1:0]  own_core [NUM_SEM];
   logic [PROC_W-1:0]  own_proc [NUM_SEM];
   logic [NUM_SEM-1:0] en_a  [NUM_CORE];
   logic [NUM_SEM-1:0] sts_a [NUM_CORE];

   assign acc_wr    = bus_sel && bus_wr;
   assign acc_rd    = bus_sel && !bus_wr;
   assign in_sem    = bus_addr < SEM_LIM;
   assign sem_idx   = bus_addr[IDX_W-1:0];
   assign alias_off = bus_addr - A_ALIAS;
   assign in_alias  = (bus_addr >= A_ALIAS) && (alias_off < SEM_LIM);
   assign alias_idx = alias_off[IDX_W-1:0];
   assign core_off  = bus_addr - A_CORE;
   assign core_idx  = core_off[7:2];
   assign core_reg  = pc_reg_e'(core_off[1:0]);
   assign in_core   = (bus_addr >= A_CORE) && (core_idx < CORE_LIM);
   assign bulk_hit  = acc_wr && (bus_addr == A_BULK) &&
                      (bus_wdata[KEY_LSB +: KEY_W] == key_q);

   function automatic logic [31:0] sem_word(input logic l, input logic [CORE_W-1:0] c,
                                            input logic [PROC_W-1:0] p);
      logic [31:0] w;
      w = '0;
      w[LOCK_BIT]          = l;
      w[CORE_LSB +: CORE_W] = c;
      w[0 +: PROC_W]       = p;
      return w;
   endfunction

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
      logic hit_w, hit_a;
      assign hit_w = acc_wr && in_sem && (sem_idx == IDX_W'(i));
      if (ALIAS_EN) begin : g_alias
         assign hit_a = acc_rd && in_alias && (alias_idx == IDX_W'(i));
      end else begin : g_no_alias
         assign hit_a = 1'b0;
      end
      sem_cell #(.CORE_W(CORE_W), .PROC_W(PROC_W)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .lock_wr   (hit_w && bus_wdata[LOCK_BIT]),
         .unlock_wr (hit_w && !bus_wdata[LOCK_BIT]),
         .rlock_rd  (hit_a),
         .bulk_clr  (bulk_hit),
         .req_core  (bus_mid),
         .req_proc  (bus_wdata[PROC_W-1:0]),
         .bulk_core (bus_wdata[CORE_LSB +: CORE_W]),
         .locked    (lock_v[i]),
         .own_core  (own_core[i]),
         .own_proc  (own_proc[i]),
         .freed     (freed_v[i])
      );
   end

   for (genvar k = 0; k < NUM_CORE; k++) begin : g_core
      logic sel_k;
      assign sel_k = acc_wr && in_core && (core_idx == 6'(k));
      sem_irq #(.NUM_SEM(NUM_SEM)) u_irq (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_wr  (sel_k && core_reg == PC_EN),
         .clr_wr (sel_k && core_reg == PC_CLR),
         .wmask  (bus_wdata[NUM_SEM-1:0]),
         .freed  (freed_v),
         .en_q   (en_a[k]),
         .sts_q  (sts_a[k]),
         .irq    (irq[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           key_q <= '0;
      else if (acc_wr && bus_addr == A_KEY) key_q <= bus_wdata[KEY_W-1:0];
   end

   always_comb begin
      rd_next = '0;
      if (in_sem) begin
         rd_next = sem_word(lock_v[sem_idx], own_core[sem_idx], own_proc[sem_idx]);
      end else if (ALIAS_EN && in_alias) begin
         if (lock_v[alias_idx])
            rd_next = sem_word(1'b1, own_core[alias_idx], own_proc[alias_idx]);
         else
            rd_next = sem_word(1'b1, bus_mid, '0);
      end else if (bus_addr == A_KEY) begin
         rd_next[KEY_W-1:0] = key_q;
      end else if (in_core) begin
         for (int k = 0; k < NUM_CORE; k++) begin
            if (core_idx == 6'(k)) begin
               if (core_reg == PC_EN)  rd_next[NUM_SEM-1:0] = en_a[k];
               if (core_reg == PC_STS) rd_next[NUM_SEM-1:0] = sts_a[k];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (acc_rd) bus_rdata <= rd_next;
   end

   AST_BAD_KEY_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr && bus_addr == A_BULK && bus_wdata[KEY_LSB +: KEY_W] != key_q
      |=> $stable(lock_v)); // R8
   AST_READ_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd && in_sem |=> $stable(lock_v)); // R2
endmodule

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_mid = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [31:0] v;
      string       tag;
   } exp_t;
   exp_t sb[$];

   localparam logic [3:0] CA = 4'h3;
   localparam logic [3:0] CB = 4'h1;

   always #4 clk = ~clk;

   sem_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mid(bus_mid),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] sw(input logic l, input logic [3:0] c, input logic [7:0] p);
      return {l, 19'b0, c, p};
   endfunction

   task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d; bus_mid = m;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [3:0] m, input logic [31:0] e, input string tag);
      exp_t it;
      it.v = e; it.tag = tag;
      sb.push_back(it);
      acc(1'b0, a, 32'h0, m);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, e);
      end
   endtask

   // monitor: pops an expected item for each read seen at a clock edge
   initial begin
      forever begin
         @(posedge clk);
         if (bus_sel && !bus_wr) begin
            #2;
            if (sb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
               exp_t it;
               it = sb.pop_front();
               chk(bus_rdata, it.v, it.tag);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk({30'b0, irq}, 32'h0, "R1 irq");
      rd(8'h00, CA, 32'h0, "R1 sem0");
      rd(8'h1F, CA, 32'h0, "R1 sem31");
      rd(8'h41, CA, 32'h0, "R1 key");
      rd(8'h4A, CA, 32'h0, "R1 status0");
      rd(8'h48, CA, 32'h0, "R1 enable0");
      // R3 two-step lock, R2 layout
      acc(1'b1, 8'h00, 32'h8000_0012, CA);
      rd(8'h00, CA, sw(1, CA, 8'h12), "R3 two-step lock");
      // R4 relock ignored
      acc(1'b1, 8'h00, 32'h8000_0005, CB);
      rd(8'h00, CB, sw(1, CA, 8'h12), "R4 other core relock");
      acc(1'b1, 8'h00, 32'h8000_0034, CA);
      rd(8'h00, CA, sw(1, CA, 8'h12), "R4 owner relock");
      // R6 protected release
      acc(1'b1, 8'h00, 32'h0000_0012, CB);
      rd(8'h00, CA, sw(1, CA, 8'h12), "R6 wrong core release");
      acc(1'b1, 8'h00, 32'h0000_0099, CA);
      rd(8'h00, CA, sw(1, CA, 8'h12), "R6 wrong proc release");
      acc(1'b1, 8'h00, 32'h0000_0012, CA);
      rd(8'h00, CA, 32'h0, "R6 matching release");
      // R5 one-step alias lock
      rd(8'h25, CB, sw(1, CB, 8'h00), "R5 alias lock");
      rd(8'h05, CA, sw(1, CB, 8'h00), "R5 alias owner kept");
      rd(8'h25, CA, sw(1, CB, 8'h00), "R5 alias on locked");
      rd(8'h05, CA, sw(1, CB, 8'h00), "R5 locked unchanged");
      // R7 key
      acc(1'b1, 8'h41, 32'h1234_BEEF, CA);
      rd(8'h41, CA, 32'h0000_BEEF, "R7 key readback");
      // R9 interrupt on free of enabled sem
      acc(1'b1, 8'h48, 32'h0000_0020, CA);
      rd(8'h48, CA, 32'h0000_0020, "R9 enable0 readback");
      acc(1'b1, 8'h05, 32'h0000_0000, CB);
      chk({30'b0, irq}, 32'h1, "R10 irq after free");
      rd(8'h4A, CA, 32'h0000_0020, "R9 status0 set");
      rd(8'h4E, CB, 32'h0000_0000, "R9 status1 untouched");
      // R10 clear
      acc(1'b1, 8'h49, 32'h0000_0020, CA);
      chk({30'b0, irq}, 32'h0, "R10 irq after clear");
      rd(8'h4A, CA, 32'h0, "R10 status0 cleared");
      // R8 bulk clear
      for (int i = 1; i < 4; i++) acc(1'b1, 8'(i), 32'h8000_0007, CA);
      acc(1'b1, 8'h04, 32'h8000_0009, CB);
      acc(1'b1, 8'h40, {16'hBEEE, 4'h0, CA, 8'h00}, CB);
      rd(8'h02, CA, sw(1, CA, 8'h07), "R8 wrong key ignored");
      acc(1'b1, 8'h40, {16'hBEEF, 4'h0, CA, 8'h00}, CB);
      rd(8'h01, CA, 32'h0, "R8 bulk freed 1");
      rd(8'h03, CA, 32'h0, "R8 bulk freed 3");
      rd(8'h04, CA, sw(1, CB, 8'h09), "R8 other core kept");
      rd(8'h4A, CA, 32'h0, "R9 disabled free sets nothing");
      chk({30'b0, irq}, 32'h0, "R10 irq idle");
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         checks++; errors++;
         $display("FAIL R2 reads not returned actual=%0d expected=0", sb.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule